// File: doc/BRIEF.md
# Lockable Peripheral Clock Divider Bank

This block derives three peripheral bus clocks from the system clock. Each channel has a 32-bit control/status word holding a 7-bit divisor field, an output-enable flag and a read-only ready flag. The divide ratio is the field value plus one, so the range runs from divide-by-1 to divide-by-128. At divide-by-1 the output is the system clock gated by the enable. At every other ratio the output comes from a register and starts each period with its low phase.

Writes to the divider words are protected. Software first writes a two-word key to a key register in back-to-back bus cycles. After that, the bank accepts divider writes until a different value is written to the key register.

A ratio change does not take effect at once. The channel records the new divisor and lowers its ready flag. It moves to the new ratio only when the current output period ends, so no short pulse appears on the output. While ready is low, every write to that channel is refused. The first channel feeds core system logic, so its output cannot be turned off.

Top module: `pbdiv_bank`

## Requirements
- R1: With divisor field value F (bits 6:0), a running channel's output period is F+1 system clock cycles.
- R2: After reset, every channel word reads 0x0000_8801: field 1, enable (bit 15) 1, ready (bit 11) 1.
- R3: A write to a channel word made while the bank is locked changes nothing in that word.
- R4: The bank unlocks only when 0x3C5A_9617 and then 0xC3A5_69E8 are written to the key register at 0x100 in two consecutive cycles. A key sequence that is interrupted or has a gap fails. Writing any other value to the key register relocks the bank.
- R5: While a channel is switching ratio, its ready bit reads 0 and any write to that channel is ignored.
- R6: A new ratio takes over only at the end of the current output period. The field readback and the ready bit change together in the cycle it takes over.
- R7: On channels 2 and 3, enable 0 holds the output low. Setting enable to 1 again starts a fresh period with its low phase.
- R8: The enable bit of channel 1 always reads 1, and writing 0 to it has no effect.
- R9: At ratios of 2 or more, the output is high for floor(N/2) cycles at the end of each period of N cycles.
- R10: At ratio 1 (field 0), the output follows the system clock while the channel is enabled.
- R11: Channel words sit at 0x130, 0x140 and 0x150. Unused bits, unmapped addresses and the key register read 0. Writes to read-only bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 12 | Byte address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pb_clk | output | 3 | Peripheral clock outputs, index 0 is channel 1 |

## Verification
The bench measures period and high time at ratios from 2 to 128. A design that drops the +1 offset or rounds the high phase up would show a mismatch there. It starts a switch at a known point in a long period. It then checks that ready drops, that the old ratio is still shown, and that a second write is refused. A design that applied writes at once or queued the later write would fail these checks. It also tries a key sequence with a gap, a relock, and locked writes, any of which a loosely decoded key would let through. It disables and re-enables channel 3, runs it at divide-by-1, and clears the enable on channel 1, which must stay on.

// File: rtl/pbdiv_pkg.sv
package pbdiv_pkg;

    localparam int NUM_CH   = 3;
    localparam int FIELD_W  = 7;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int EN_POS   = 15;
    localparam int RDY_POS  = 11;

    localparam logic [ADDR_W-1:0] KEY_ADDR  = 12'h100;
    localparam logic [ADDR_W-1:0] CH_BASE   = 12'h130;
    localparam logic [ADDR_W-1:0] CH_STRIDE = 12'h010;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h3C5A_9617;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'hC3A5_69E8;

    typedef struct packed {
        logic               en;
        logic               rdy;
        logic [FIELD_W-1:0] field;
    } ch_stat_t;

    function automatic logic [ADDR_W-1:0] chan_addr(input int idx);
        return CH_BASE + CH_STRIDE * ADDR_W'(idx);
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(input ch_stat_t s);
        logic [DATA_W-1:0] w;
        w                = '0;
        w[EN_POS]        = s.en;
        w[RDY_POS]       = s.rdy;
        w[FIELD_W-1:0]   = s.field;
        return w;
    endfunction

    // Output level for count c within a period of (f+1) cycles:
    // low first, high for the last floor((f+1)/2) cycles.
    function automatic logic phase_high(input logic [15:0] c, input logic [15:0] f);
        logic [16:0] n;
        logic [16:0] hi;
        n  = {1'b0, f} + 17'd1;
        hi = n >> 1;
        return {1'b0, c} >= (n - hi);
    endfunction

endpackage

// File: rtl/pbdiv_unlock.sv
module pbdiv_unlock
    import pbdiv_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked,
    output logic              armed
);

    logic key_wr;
    logic unlocked_q;
    logic armed_q;

    assign key_wr = wr_en && (addr == AW'(KEY_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked_q <= 1'b0;
            armed_q    <= 1'b0;
        end else begin
            // the first key word arms for exactly one cycle
            armed_q <= key_wr && (wdata == KEY_FIRST);
            if (key_wr) begin
                unlocked_q <= armed_q && (wdata == KEY_SECOND);
            end
        end
    end

    assign unlocked = unlocked_q;
    assign armed    = armed_q;

endmodule

// File: rtl/pbdiv_channel.sv
module pbdiv_channel
    import pbdiv_pkg::*;
#(
    parameter int FW       = FIELD_W,
    parameter bit FIXED_ON = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_acc,
    input  logic [FW-1:0] wr_field,
    input  logic          wr_enable,
    output logic [FW-1:0] field,
    output logic [FW-1:0] pend,
    output logic          enable,
    output logic          ready,
    output logic          clk_out
);

    logic [FW-1:0] field_q;
    logic [FW-1:0] pend_q;
    logic [FW-1:0] cnt_q;
    logic [FW-1:0] cnt_nxt;
    logic          busy_q;
    logic          en_q;
    logic          div_q;
    logic          period_end;
    logic          pass_mode;

    assign period_end = (cnt_q == field_q);
    assign cnt_nxt    = period_end ? '0 : cnt_q + 1'b1;
    assign pass_mode  = (field_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= FW'(1);
            pend_q  <= FW'(1);
            busy_q  <= 1'b0;
            en_q    <= 1'b1;
            cnt_q   <= '0;
            div_q   <= 1'b0;
        end else begin
            if (wr_acc && !busy_q) begin
                pend_q <= wr_field;
                if (wr_field != field_q) begin
                    busy_q <= 1'b1;
                end
                if (!FIXED_ON) begin
                    en_q <= wr_enable;
                end
            end
            if (!en_q) begin
                cnt_q <= '0;
                div_q <= 1'b0;
                if (busy_q) begin
                    field_q <= pend_q;
                    busy_q  <= 1'b0;
                end
            end else if (busy_q && period_end) begin
                field_q <= pend_q;
                busy_q  <= 1'b0;
                cnt_q   <= '0;
                div_q   <= 1'b0;
            end else begin
                cnt_q <= cnt_nxt;
                div_q <= phase_high(16'(cnt_nxt), 16'(field_q));
            end
        end
    end

    assign field   = field_q;
    assign pend    = pend_q;
    assign enable  = en_q;
    assign ready   = !busy_q;
    assign clk_out = en_q & (pass_mode ? clk : div_q);

endmodule

// File: rtl/pbdiv_bank.sv
module pbdiv_bank
    import pbdiv_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int DIV_W = FIELD_W,
    parameter int AW    = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    pb_clk
);

    logic                   unlocked;
    logic                   armed;
    logic [NCH*DIV_W-1:0]   field_flat;
    logic [NCH*DIV_W-1:0]   pend_flat;
    logic [NCH-1:0]         ch_en;
    logic [NCH-1:0]         ch_rdy;
    logic [NCH-1:0]         ch_hit;

    pbdiv_unlock #(.AW(AW)) u_unlock (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .unlocked (unlocked),
        .armed    (armed)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_hit[i] = (addr == AW'(chan_addr(i)));

        pbdiv_channel #(
            .FW       (DIV_W),
            .FIXED_ON (i == 0)
        ) u_ch (
            .clk       (clk),
            .rst       (rst),
            .wr_acc    (wr_en && unlocked && ch_hit[i]),
            .wr_field  (wdata[DIV_W-1:0]),
            .wr_enable (wdata[EN_POS]),
            .field     (field_flat[i*DIV_W +: DIV_W]),
            .pend      (pend_flat[i*DIV_W +: DIV_W]),
            .enable    (ch_en[i]),
            .ready     (ch_rdy[i]),
            .clk_out   (pb_clk[i])
        );
    end

    always_comb begin
        ch_stat_t s;
        rdata = '0;
        s     = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) begin
                s.en    = ch_en[i];
                s.rdy   = ch_rdy[i];
                s.field = FIELD_W'(field_flat[i*DIV_W +: DIV_W]);
                rdata   = pack_stat(s);
            end
        end
    end

endmodule

// File: rtl/pbdiv_bank_chk.sv
module pbdiv_bank_chk
    import pbdiv_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int DIV_W = FIELD_W,
    parameter int AW    = ADDR_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [AW-1:0]        addr,
    input logic [DATA_W-1:0]    wdata,
    input logic                 unlocked,
    input logic                 armed,
    input logic [NCH*DIV_W-1:0] pend_flat,
    input logic [NCH*DIV_W-1:0] field_flat,
    input logic [NCH-1:0]       rdy,
    input logic [NCH-1:0]       en,
    input logic [NCH-1:0]       pb_clk
);

    assert_locked_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !unlocked) |=> ($stable(pend_flat) && $stable(en)));

    assert_key_unarmed_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(KEY_ADDR) && !armed) |=> !unlocked);

    assert_key_relock_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(KEY_ADDR) && wdata != KEY_SECOND) |=> !unlocked);

    assert_ch1_always_on_R8: assert property (@(posedge clk) disable iff (rst)
        en[0]);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_busy_refuse_R5: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == AW'(chan_addr(i)) && !rdy[i])
            |=> ($stable(pend_flat[i*DIV_W +: DIV_W]) && $stable(en[i])));

        assert_switch_only_busy_R6: assert property (@(posedge clk) disable iff (rst)
            !$stable(field_flat[i*DIV_W +: DIV_W]) |-> !$past(rdy[i]));

        if (i > 0) begin : g_off
            assert_disabled_low_R7: assert property (@(posedge clk) disable iff (rst)
                !en[i] |-> !pb_clk[i]);
        end
    end

endmodule

bind pbdiv_bank pbdiv_bank_chk #(.NCH(NCH), .DIV_W(DIV_W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .unlocked   (unlocked),
    .armed      (armed),
    .pend_flat  (pend_flat),
    .field_flat (field_flat),
    .rdy        (ch_rdy),
    .en         (ch_en),
    .pb_clk     (pb_clk)
);

// File: tb/pbdiv_bank_test.sv
module pbdiv_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_KEY = 12'h100;
    localparam logic [11:0] A_CH1 = 12'h130;
    localparam logic [11:0] A_CH2 = 12'h140;
    localparam logic [11:0] A_CH3 = 12'h150;
    localparam logic [31:0] K1 = 32'h3C5A_9617;
    localparam logic [31:0] K2 = 32'hC3A5_69E8;
    localparam int NVEC = 6;
    // {field, expected period, expected high time}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd1,   8'd2,   8'd1},
        {8'd2,   8'd3,   8'd1},
        {8'd4,   8'd5,   8'd2},
        {8'd6,   8'd7,   8'd3},
        {8'd9,   8'd10,  8'd5},
        {8'd127, 8'd128, 8'd64}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  pb_clk;

    int n_chk  = 0;
    int n_fail = 0;

    pbdiv_bank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pb_clk(pb_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_ready(input logic [11:0] a);
        logic [31:0] d;
        for (int k = 0; k < 400; k++) begin
            rd(a, d);
            if (d[11]) break;
        end
    endtask

    task automatic measure(input int ch, output int per, output int hi);
        logic prev;
        per = 0; hi = 0;
        @(negedge clk);
        prev = pb_clk[ch];
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (!prev && pb_clk[ch]) break;
            prev = pb_clk[ch];
        end
        for (int k = 0; k < 600; k++) begin
            per++;
            if (pb_clk[ch]) hi++;
            prev = pb_clk[ch];
            @(negedge clk);
            if (!prev && pb_clk[ch]) break;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int per, hi;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R2 reset state
        rd(A_CH1, d); chk(d == 32'h8801, "R2 ch1 reset", d, 32'h8801);
        rd(A_CH2, d); chk(d == 32'h8801, "R2 ch2 reset", d, 32'h8801);
        rd(A_CH3, d); chk(d == 32'h8801, "R2 ch3 reset", d, 32'h8801);
        measure(1, per, hi); chk(per == 2, "R1 reset ratio 2", per, 2);

        // R11 unmapped and key reads
        rd(12'h134, d); chk(d == 0, "R11 unmapped read", d, 0);
        rd(A_KEY, d);   chk(d == 0, "R11 key read", d, 0);

        // R3 locked write ignored
        wr(A_CH2, 32'h0000_0009);
        rd(A_CH2, d); chk(d == 32'h8801, "R3 locked write", d, 32'h8801);

        // R4 key with a gap, and key interrupted by another write
        wr(A_KEY, K1); @(negedge clk); wr(A_KEY, K2);
        wr(A_CH2, 32'h0000_0009);
        rd(A_CH2, d); chk(d == 32'h8801, "R4 gapped key", d, 32'h8801);
        wr(A_KEY, K1); wr(A_CH3, 32'h0); wr(A_KEY, K2);
        wr(A_CH2, 32'h0000_0009);
        rd(A_CH2, d); chk(d == 32'h8801, "R4 interrupted key", d, 32'h8801);

        // proper unlock
        wr(A_KEY, K1); wr(A_KEY, K2);

        // R1 / R9 vector walk on channel 2
        foreach (VEC[v]) begin
            wait_ready(A_CH2);
            wr(A_CH2, 32'h0000_8000 | 32'(VEC[v][23:16]));
            wait_ready(A_CH2);
            rd(A_CH2, d);
            chk(d == (32'h8800 | 32'(VEC[v][23:16])), "R1 readback", d, 32'h8800 | 32'(VEC[v][23:16]));
            measure(1, per, hi);
            chk(per == int'(VEC[v][15:8]), "R1 period", per, 32'(VEC[v][15:8]));
            chk(hi == int'(VEC[v][7:0]), "R9 high time", hi, 32'(VEC[v][7:0]));
        end

        // R5 / R6: measure ended at a rise of a 128 period (63 cycles left)
        wr(A_CH2, 32'h0000_8003);
        rd(A_CH2, d);
        chk(d[11] == 1'b0, "R5 ready low while switching", 32'(d[11]), 0);
        chk(d[6:0] == 7'd127, "R6 old ratio kept until period end", 32'(d[6:0]), 127);
        wr(A_CH2, 32'h0000_8007);
        wait_ready(A_CH2);
        rd(A_CH2, d); chk(d == 32'h8803, "R5 busy write refused", d, 32'h8803);
        measure(1, per, hi); chk(per == 4, "R6 new ratio active", per, 4);

        // R11 read-only and unused bits ignored on write
        wr(A_CH2, 32'hFFFF_F785);
        wait_ready(A_CH2);
        rd(A_CH2, d); chk(d == 32'h8805, "R11 write masking", d, 32'h8805);

        // R8 channel 1 enable cannot be cleared
        wr(A_CH1, 32'h0000_0003);
        wait_ready(A_CH1);
        rd(A_CH1, d); chk(d == 32'h8803, "R8 ch1 enable stays", d, 32'h8803);
        measure(0, per, hi); chk(per == 4, "R8 ch1 still runs", per, 4);

        // R7 disable and re-enable channel 3
        wr(A_CH3, 32'h0000_0001);
        rd(A_CH3, d); chk(d == 32'h0801, "R7 ch3 disabled readback", d, 32'h0801);
        begin
            int highs = 0;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (pb_clk[2]) highs++;
            end
            chk(highs == 0, "R7 disabled output low", highs, 0);
        end
        wr(A_CH3, 32'h0000_8001);
        @(negedge clk);
        chk(pb_clk[2] == 1'b0, "R7 re-enable starts low", 32'(pb_clk[2]), 0);
        @(negedge clk);
        chk(pb_clk[2] == 1'b1, "R7 then high phase", 32'(pb_clk[2]), 1);

        // R10 divide by one follows the system clock
        wr(A_CH3, 32'h0000_8000);
        wait_ready(A_CH3);
        begin
            int bad = 0;
            for (int k = 0; k < 8; k++) begin
                @(posedge clk); #(CLK_PERIOD/4);
                if (pb_clk[2] !== 1'b1) bad++;
                @(negedge clk); #1;
                if (pb_clk[2] !== 1'b0) bad++;
            end
            chk(bad == 0, "R10 pass-through", bad, 0);
        end

        // R4 relock then write ignored
        wr(A_KEY, 32'h0);
        wr(A_CH2, 32'h0000_8009);
        rd(A_CH2, d); chk(d == 32'h8805, "R4 relock", d, 32'h8805);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule